// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block sits behind a host-visible register file of a memory-expander device and decides what happens to each mailbox command. The host writes a command register that carries a command-set byte, a command byte and an input payload length, and then requests the doorbell. While the doorbell is set, the block owns the command. It joins the two bytes into a 16-bit opcode and looks that opcode up in a fixed table of supported commands. It then compares the input length against the length that opcode requires.

A command that passes both checks is handed to an external handler through a one-cycle start pulse. The block then waits for the handler's done pulse, which carries a return code and an output length. A command that fails either check is completed at once with an error code, and no handler is started. In both cases the block writes the status and command registers in one cycle, then clears the doorbell in the following cycle. The host polls the doorbell to learn that the result is ready.

Top module: `mbox_dispatch`

## Requirements
- R1: While the doorbell is clear, a command-register write loads the register with the layout set byte in bits [7:0], command byte in bits [15:8] and input length in bits [LEN_W+15:16].
- R2: A doorbell request while the doorbell is clear sets it on the next edge. While the doorbell is set, doorbell requests and command-register writes have no effect and are not queued.
- R3: The opcode is set*256 + command. The supported opcodes are 0x0100–0x0103, 0x0200, 0x0300, 0x0301, 0x0400, 0x0401, 0x4000, 0x4100, 0x4102 and 0x4103. Any other opcode completes with return code 0x0003, and no start pulse is issued.
- R4: Required input lengths: 0x0100 needs 1, 0x0103 needs 4, 0x0301 needs 8, 0x0401 needs 0x18 and 0x4102 needs 8. Opcodes 0x0101 and 0x4103 accept any length, and every other supported opcode needs 0. A mismatch completes with return code 0x0016, and no start pulse is issued.
- R5: An accepted command raises `hnd_start` for exactly one cycle. It first appears in the second cycle after the doorbell request edge, with `hnd_opcode` and `hnd_in_len` showing the command.
- R6: When `hnd_done` is sampled high and `hnd_out_len` is at most PAYLOAD_BYTES (256 by default), the handler's return code and output length are reported unchanged.
- R7: When the handler reports an output length above PAYLOAD_BYTES, the command completes with return code 0x0004 (internal error) and an output length of 0.
- R8: On completion, the status register holds the return code in bits [15:0] and zeros in all other bits. The command register has its set and command fields at zero and its length field set to the output length.
- R9: The doorbell clears exactly one cycle after the status and command registers are written. For a command rejected at decode, the doorbell stays set for three cycles.
- R10: A command rejected at decode reports its own input length, unchanged, as the output length.
- R11: After reset, the command register, the status register, the doorbell and `hnd_start` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | LEN_W+16 | Host write data for the command register |
| db_req | input | 1 | Host request to set the doorbell |
| cmd_reg | output | LEN_W+16 | Command register contents |
| sts_reg | output | STS_W | Status register contents |
| doorbell | output | 1 | Doorbell bit; high while a command is owned by the block |
| hnd_start | output | 1 | One-cycle start pulse to the handler |
| hnd_opcode | output | 16 | Opcode of the current command |
| hnd_in_len | output | LEN_W | Input length of the current command |
| hnd_done | input | 1 | Handler completion pulse |
| hnd_rc | input | 16 | Handler return code, valid with hnd_done |
| hnd_out_len | input | LEN_W | Handler output length, valid with hnd_done |

## Verification
The assertions assume that `hnd_done` is pulsed only once per start pulse, and only after that pulse, while the block is waiting for the handler. They also assume that the handler's return code and output length are valid in the same cycle as `hnd_done`. The bench's handler stub arms itself only when it sees `hnd_start`, and it returns exactly one done pulse after a programmed delay of at least one cycle. The host stimulus sends writes and doorbell requests during busy periods on purpose, and the block is specified to ignore them.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int RC_W = 16;

   localparam logic [RC_W-1:0] RC_OK       = 16'h0000;
   localparam logic [RC_W-1:0] RC_UNSUP    = 16'h0003;
   localparam logic [RC_W-1:0] RC_INTERNAL = 16'h0004;
   localparam logic [RC_W-1:0] RC_BAD_LEN  = 16'h0016;

   localparam int OP_COUNT = 13;
   localparam int LEN_FREE = -1;

   localparam logic [15:0] OP_CODES [OP_COUNT] = '{
      16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200,
      16'h0300, 16'h0301, 16'h0400, 16'h0401, 16'h4000,
      16'h4100, 16'h4102, 16'h4103
   };

   localparam int OP_INLEN [OP_COUNT] = '{
      1, LEN_FREE, 0, 4, 0,
      0, 8, 0, 24, 0,
      0, 8, LEN_FREE
   };

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_DECODE = 3'd1,
      S_LAUNCH = 3'd2,
      S_WAIT   = 3'd3,
      S_WRITE  = 3'd4,
      S_RING   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/mbox_cmd_table.sv
module mbox_cmd_table
   import mbox_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [15:0]      opcode,
   input  logic [LEN_W-1:0] in_len,
   output logic             hit,
   output logic             len_ok
);

   logic [OP_COUNT-1:0] hit_v;
   logic [OP_COUNT-1:0] ok_v;

   for (genvar i = 0; i < OP_COUNT; i++) begin : g_entry
      assign hit_v[i] = (opcode == OP_CODES[i]);
      if (OP_INLEN[i] < 0) begin : g_free
         assign ok_v[i] = hit_v[i];
      end else begin : g_fixed
         assign ok_v[i] = hit_v[i] && (in_len == LEN_W'(OP_INLEN[i]));
      end
   end

   assign hit    = |hit_v;
   assign len_ok = |ok_v;

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
   import mbox_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int STS_W = 32,
   localparam int CMD_W = LEN_W + 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic [CMD_W-1:0] host_wdata,
   input  logic             lock,
   input  logic             wb_en,
   input  logic [RC_W-1:0]  wb_rc,
   input  logic [LEN_W-1:0] wb_len,
   output logic [CMD_W-1:0] cmd_reg,
   output logic [STS_W-1:0] sts_reg
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_reg <= '0;
         sts_reg <= '0;
      end else if (wb_en) begin
         cmd_reg <= {wb_len, 16'h0000};
         sts_reg <= STS_W'(wb_rc);
      end else if (host_wr && !lock) begin
         cmd_reg <= host_wdata;
      end
   end

   // R2: host writes cannot disturb an owned command
   p_cmd_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !wb_en) |=> $stable(cmd_reg));

   // R8: writeback clears opcode fields and upper status bits
   p_wb_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> (cmd_reg[15:0] == 16'h0000 && sts_reg[STS_W-1:RC_W] == '0));

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
   import mbox_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter int PAYLOAD_BYTES = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             db_req,
   input  logic [LEN_W-1:0] in_len,
   input  logic             hit,
   input  logic             len_ok,
   input  logic             hnd_done,
   input  logic [RC_W-1:0]  hnd_rc,
   input  logic [LEN_W-1:0] hnd_out_len,
   output logic             doorbell,
   output logic             hnd_start,
   output logic             wb_en,
   output logic [RC_W-1:0]  wb_rc,
   output logic [LEN_W-1:0] wb_len
);

   localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(PAYLOAD_BYTES);

   seq_state_e       state;
   logic [RC_W-1:0]  res_rc;
   logic [LEN_W-1:0] res_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         doorbell <= 1'b0;
         res_rc   <= '0;
         res_len  <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (db_req) begin
                  doorbell <= 1'b1;
                  state    <= S_DECODE;
               end
            end
            S_DECODE: begin
               if (!hit) begin
                  res_rc  <= RC_UNSUP;
                  res_len <= in_len;
                  state   <= S_WRITE;
               end else if (!len_ok) begin
                  res_rc  <= RC_BAD_LEN;
                  res_len <= in_len;
                  state   <= S_WRITE;
               end else begin
                  state   <= S_LAUNCH;
               end
            end
            S_LAUNCH: state <= S_WAIT;
            S_WAIT: begin
               if (hnd_done) begin
                  if (hnd_out_len > LEN_LIMIT) begin
                     res_rc  <= RC_INTERNAL;
                     res_len <= '0;
                  end else begin
                     res_rc  <= hnd_rc;
                     res_len <= hnd_out_len;
                  end
                  state <= S_WRITE;
               end
            end
            S_WRITE: state <= S_RING;
            S_RING: begin
               doorbell <= 1'b0;
               state    <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign hnd_start = (state == S_LAUNCH);
   assign wb_en     = (state == S_WRITE);
   assign wb_rc     = res_rc;
   assign wb_len    = res_len;

   // R5: start is a single-cycle pulse
   p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |=> !hnd_start);

   // R5: a handler is only started for a command the block owns
   p_start_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |-> doorbell);

   // R9: doorbell drops one cycle after the register writeback
   p_bell_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> $past(wb_en, 2));

   // R2: doorbell set only from a request
   p_bell_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(doorbell) |-> $past(db_req));

endmodule

// File: rtl/mbox_dispatch.sv
module mbox_dispatch
   import mbox_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter int STS_W         = 32,
   parameter int PAYLOAD_BYTES = 256,
   localparam int CMD_W = LEN_W + 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             db_req,
   output logic [CMD_W-1:0] cmd_reg,
   output logic [STS_W-1:0] sts_reg,
   output logic             doorbell,
   output logic             hnd_start,
   output logic [15:0]      hnd_opcode,
   output logic [LEN_W-1:0] hnd_in_len,
   input  logic             hnd_done,
   input  logic [RC_W-1:0]  hnd_rc,
   input  logic [LEN_W-1:0] hnd_out_len
);

   if (LEN_W < 8 || LEN_W > 24) begin : g_bad_len_w
      $error("LEN_W out of supported range");
   end
   if (STS_W <= RC_W) begin : g_bad_sts_w
      $error("STS_W must exceed the return code width");
   end
   if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES >= (1 << LEN_W)) begin : g_bad_payload
      $error("PAYLOAD_BYTES must fit in the length field");
   end

   logic             hit;
   logic             len_ok;
   logic             wb_en;
   logic [RC_W-1:0]  wb_rc;
   logic [LEN_W-1:0] wb_len;

   assign hnd_opcode = {cmd_reg[7:0], cmd_reg[15:8]};
   assign hnd_in_len = cmd_reg[CMD_W-1:16];

   mbox_cmd_table #(.LEN_W(LEN_W)) u_table (
      .opcode (hnd_opcode),
      .in_len (hnd_in_len),
      .hit    (hit),
      .len_ok (len_ok)
   );

   mbox_seq #(.LEN_W(LEN_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .db_req      (db_req),
      .in_len      (hnd_in_len),
      .hit         (hit),
      .len_ok      (len_ok),
      .hnd_done    (hnd_done),
      .hnd_rc      (hnd_rc),
      .hnd_out_len (hnd_out_len),
      .doorbell    (doorbell),
      .hnd_start   (hnd_start),
      .wb_en       (wb_en),
      .wb_rc       (wb_rc),
      .wb_len      (wb_len)
   );

   mbox_regs #(.LEN_W(LEN_W), .STS_W(STS_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (cmd_wr),
      .host_wdata (cmd_wdata),
      .lock       (doorbell),
      .wb_en      (wb_en),
      .wb_rc      (wb_rc),
      .wb_len     (wb_len),
      .cmd_reg    (cmd_reg),
      .sts_reg    (sts_reg)
   );

   // R3: a rejected opcode never reaches the handler
   p_unsup_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |-> hit);

endmodule

// File: tb/mbox_dispatch_bench.sv
`timescale 1ns/1ps
module mbox_dispatch_bench;

   localparam int LEN_W = 16;
   localparam int STS_W = 32;
   localparam int PAYLOAD = 256;
   localparam int CMD_W = LEN_W + 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_wr = 1'b0;
   logic [CMD_W-1:0] cmd_wdata = '0;
   logic             db_req = 1'b0;
   logic [CMD_W-1:0] cmd_reg;
   logic [STS_W-1:0] sts_reg;
   logic             doorbell;
   logic             hnd_start;
   logic [15:0]      hnd_opcode;
   logic [LEN_W-1:0] hnd_in_len;
   logic             hnd_done = 1'b0;
   logic [15:0]      hnd_rc = '0;
   logic [LEN_W-1:0] hnd_out_len = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mbox_dispatch #(.LEN_W(LEN_W), .STS_W(STS_W), .PAYLOAD_BYTES(PAYLOAD)) u_mbox_dispatch (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .db_req(db_req),
      .cmd_reg(cmd_reg), .sts_reg(sts_reg), .doorbell(doorbell), .hnd_start(hnd_start),
      .hnd_opcode(hnd_opcode), .hnd_in_len(hnd_in_len), .hnd_done(hnd_done),
      .hnd_rc(hnd_rc), .hnd_out_len(hnd_out_len)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // required input length per opcode: -1 any length, -2 not supported
   function automatic int need_len(input int op);
      case (op)
         'h0100: return 1;
         'h0101: return -1;
         'h0103: return 4;
         'h0301: return 8;
         'h0401: return 24;
         'h4102: return 8;
         'h4103: return -1;
         'h0102, 'h0200, 'h0300, 'h0400, 'h4000, 'h4100: return 0;
         default: return -2;
      endcase
   endfunction

   // behavioural reference: progress counter through a command's life
   int m_step = 0;
   longint m_cmd = 0, m_sts = 0;
   int m_db = 0, m_rc = 0, m_len = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_step = 0; m_cmd = 0; m_sts = 0; m_db = 0; m_rc = 0; m_len = 0;
      end else begin
         int op, in, need;
         op = int'(m_cmd[7:0]) * 256 + int'(m_cmd[15:8]);
         in = int'(m_cmd[31:16]);
         need = need_len(op);
         case (m_step)
            0: begin
               if (cmd_wr) m_cmd = longint'(cmd_wdata);
               if (db_req) begin m_db = 1; m_step = 1; end
            end
            1: begin
               if (need == -2) begin m_rc = 3; m_len = in; m_step = 4; end
               else if (need >= 0 && need != in) begin m_rc = 'h16; m_len = in; m_step = 4; end
               else m_step = 2;
            end
            2: m_step = 3;
            3: if (hnd_done) begin
                  if (int'(hnd_out_len) > PAYLOAD) begin m_rc = 4; m_len = 0; end
                  else begin m_rc = int'(hnd_rc); m_len = int'(hnd_out_len); end
                  m_step = 4;
               end
            4: begin
               m_cmd = longint'(m_len) * 65536;
               m_sts = longint'(m_rc);
               m_step = 5;
            end
            default: begin m_db = 0; m_step = 0; end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R9 doorbell vs model", longint'(doorbell), longint'(m_db));
         check("R8 cmd_reg vs model", longint'(cmd_reg), m_cmd);
         check("R8 sts_reg vs model", longint'(sts_reg), m_sts);
         check("R5 hnd_start vs model", longint'(hnd_start), longint'(m_step == 2));
      end
   end

   // handler stub
   int h_delay = 1;
   int h_cnt = 0;
   logic [15:0] h_rc_cfg = '0;
   logic [LEN_W-1:0] h_len_cfg = '0;
   int starts = 0;
   int last_op = 0, last_in = 0;

   always @(negedge clk) begin
      hnd_done = 1'b0;
      if (hnd_start) begin
         starts++;
         last_op = int'(hnd_opcode);
         last_in = int'(hnd_in_len);
         h_cnt = h_delay;
      end else if (h_cnt > 0) begin
         h_cnt--;
         if (h_cnt == 0) begin
            hnd_done = 1'b1;
            hnd_rc = h_rc_cfg;
            hnd_out_len = h_len_cfg;
         end
      end
   end

   int bell_cycles = 0;
   int start_at = 0;

   task automatic issue(input int set, input int cmd, input int len);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_wdata = {LEN_W'(len), 8'(cmd), 8'(set)};
      db_req = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      db_req = 1'b0;
   endtask

   task automatic settle();
      bell_cycles = 0;
      start_at = 0;
      for (int i = 0; i < 200; i++) begin
         if (!doorbell) break;
         bell_cycles++;
         if (hnd_start && start_at == 0) start_at = bell_cycles;
         @(negedge clk);
      end
   endtask

   task automatic run(input int set, input int cmd, input int len);
      issue(set, cmd, len);
      settle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 cmd_reg reset", longint'(cmd_reg), 0);
      check("R11 sts_reg reset", longint'(sts_reg), 0);
      check("R11 doorbell reset", longint'(doorbell), 0);
      check("R11 hnd_start reset", longint'(hnd_start), 0);

      // R1 write without doorbell
      cmd_wr = 1'b1; cmd_wdata = 32'h0005_0201;
      @(negedge clk);
      cmd_wr = 1'b0;
      check("R1 cmd layout", longint'(cmd_reg), 'h0005_0201);
      check("R1 opcode view", longint'(hnd_opcode), 'h0102);
      check("R1 doorbell still clear", longint'(doorbell), 0);

      // R3 unsupported, R10 length kept, R9 timing
      s0 = starts;
      run('h05, 'h00, 12);
      check("R3 unsupported rc", longint'(sts_reg), 3);
      check("R10 input length kept", longint'(cmd_reg), longint'(12) * 65536);
      check("R9 bell cycles on reject", bell_cycles, 3);
      check("R3 no start", starts - s0, 0);
      run('h41, 'h01, 0);
      check("R3 gap opcode rc", longint'(sts_reg), 3);

      // R4 length mismatch
      s0 = starts;
      run('h03, 'h01, 4);
      check("R4 bad length rc", longint'(sts_reg), 'h16);
      check("R4 no start", starts - s0, 0);
      check("R10 length echoed", longint'(cmd_reg), longint'(4) * 65536);
      run('h01, 'h00, 0);
      check("R4 needs one byte", longint'(sts_reg), 'h16);

      // R4 any length, R5 start timing
      h_delay = 1; h_rc_cfg = 16'h0000; h_len_cfg = 16'd0;
      s0 = starts;
      run('h41, 'h03, 77);
      check("R5 single start", starts - s0, 1);
      check("R5 start cycle", start_at, 2);
      check("R5 opcode shown", last_op, 'h4103);
      check("R5 len shown", last_in, 77);
      check("R4 free length ok", longint'(sts_reg), 0);

      // R6 normal completion
      h_delay = 3; h_rc_cfg = 16'h0000; h_len_cfg = 16'd100;
      run('h04, 'h01, 24);
      check("R6 rc", longint'(sts_reg), 0);
      check("R6 out len", longint'(cmd_reg), longint'(100) * 65536);
      h_rc_cfg = 16'h0002; h_len_cfg = 16'd256;
      run('h41, 'h02, 8);
      check("R6 handler rc", longint'(sts_reg), 2);
      check("R6 len at limit", longint'(cmd_reg), longint'(256) * 65536);

      // R7 overflow
      h_rc_cfg = 16'h0000; h_len_cfg = 16'd257;
      run('h03, 'h00, 0);
      check("R7 internal rc", longint'(sts_reg), 4);
      check("R7 len zero", longint'(cmd_reg), 0);

      // R2 busy: writes and requests ignored
      h_delay = 6; h_rc_cfg = 16'h0000; h_len_cfg = 16'd32;
      issue('h01, 'h00, 1);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_wdata = 32'h0009_0005; db_req = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0; db_req = 1'b0;
      check("R2 opcode held", longint'(hnd_opcode), 'h0100);
      settle();
      check("R2 result of owned cmd", longint'(cmd_reg), longint'(32) * 65536);
      repeat (3) @(negedge clk);
      check("R2 request not queued", longint'(doorbell), 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule